// File: doc/BRIEF.md
# Two-Port Memory with Busy-Gated Writes

This block is a 2048-word by 8-bit storage array reached through two independent ports, called left and right. Each port has its own active-low chip enable, a read/write select, an active-low output enable, an address, write data, registered read data, and two flags: one that says the port would be driving its data pins, and one that says the driven data can be trusted. All ports are sampled on one shared clock. Output pads are modelled by the drive flag and are not tristate.

Each port's write is qualified by an active-low busy level. A mode input chooses where that level comes from. In master mode an internal arbiter watches for both ports being enabled on the same address. It grants the word to the port that got there first and pulls the other port's busy output low, and that port's writes are then dropped. In slave mode the arbiter is idle and each port's busy input works only as an external write inhibit. Several slaves can share a master's busy outputs to build wider words.

A busied port still performs its read, but the read is flagged as untrustworthy. Reads always return the contents as they were before any write in the same cycle.

Top module: `dpram_busy_gated`

## Requirements
- R1: With a port's chip enable high, that port neither writes nor drives: its drive flag is 0 in the next cycle and the addressed word keeps its contents.
- R2: With chip enable low, read/write select 0 (write) and that port's effective busy high, the write data is stored at the addressed word.
- R3: With chip enable low, select 1 (read) and output enable low, the next cycle shows the addressed word on read data with the drive flag 1. With output enable high, the drive flag is 0 in the next cycle.
- R4: In slave mode a port's busy input at 1 allows its writes and at 0 blocks every write from that port.
- R5: In master mode a busy output goes low only while both chip enables are low and the two addresses are equal, and the two busy outputs are never low together.
- R6: In master mode, when the addresses start to match, the port that had been enabled on that address in the previous cycle wins and the other port is busied. If both arrive together, the left port wins. The winner keeps the grant for as long as the match lasts.
- R7: In master mode, a write from a port whose busy output is low is ignored, whatever level is on that port's busy input.
- R8: A read taken while its port's effective busy is low shows the drive flag 1 and the valid flag 0 in the next cycle. Otherwise the valid flag equals the drive flag.
- R9: When both ports write the same address in the same cycle and neither is inhibited, the left port's data is kept.
- R10: A read on one port in the same cycle as a write to the same address on the other port returns the word's previous contents.
- R11: During and right after reset, both drive and valid flags are 0 and both busy outputs are 1.
- R12: In slave mode both busy outputs stay at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1 selects master (internal arbiter), 0 selects slave |
| ceLN | input | 1 | Left chip enable, active low |
| rdWrL | input | 1 | Left select: 1 read, 0 write |
| oeLN | input | 1 | Left output enable, active low |
| addrL | input | 11 | Left address |
| wdataL | input | 8 | Left write data |
| busyInLN | input | 1 | Left external write inhibit, active low (slave mode) |
| rdataL | output | 8 | Left read data, one cycle after the read |
| rdDriveL | output | 1 | Left data pins would be driven |
| rdValidL | output | 1 | Left read data is trustworthy |
| busyOutLN | output | 1 | Left busy from the arbiter, active low |
| ceRN | input | 1 | Right chip enable, active low |
| rdWrR | input | 1 | Right select: 1 read, 0 write |
| oeRN | input | 1 | Right output enable, active low |
| addrR | input | 11 | Right address |
| wdataR | input | 8 | Right write data |
| busyInRN | input | 1 | Right external write inhibit, active low (slave mode) |
| rdataR | output | 8 | Right read data, one cycle after the read |
| rdDriveR | output | 1 | Right data pins would be driven |
| rdValidR | output | 1 | Right read data is trustworthy |
| busyOutRN | output | 1 | Right busy from the arbiter, active low |

## Verification
Every cycle, the assertions check the following:
- The two busy outputs are never low together.
- A busy output is low only when the addresses match with both ports enabled.
- A grant is held while the match lasts.
- Slave mode leaves both busy outputs high.
- A busied master port never produces a write strobe.
- The valid flag never rises without the drive flag.
- The stored word after a write equals the winning write data.

Some behaviours depend on sequences and can only be shown by the bench's scenarios:
- Which port wins when one arrived a cycle earlier.
- Old-data return on collisions between a read and a write.
- Left precedence when both ports write the same address.
- Dropped writes leaving memory untouched, checked by reading the word back later.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // strobes from control to datapath, one set per port
  typedef struct packed {
    logic wrEn;   // write this cycle
    logic rdEn;   // read with output enable this cycle
    logic rdOk;   // effective busy was high for this access
  } portStrobe_t;
endpackage

// File: rtl/dpram_ctrl.sv
module dpram_ctrl
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              ceLN,
  input  logic              rdWrL,
  input  logic              oeLN,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              busyInLN,
  input  logic              ceRN,
  input  logic              rdWrR,
  input  logic              oeRN,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              busyInRN,
  output logic              busyOutLN,
  output logic              busyOutRN,
  output portStrobe_t       strobeL,
  output portStrobe_t       strobeR
);
  logic              addrMatch;
  logic              prevActL, prevActR;
  logic [ADDR_W-1:0] prevAddrL, prevAddrR;
  logic              leftOld, rightOld;
  owner_e            ownerQ, winner;
  logic              effBusyLN, effBusyRN;

  assign addrMatch = !ceLN && !ceRN && (addrL == addrR);
  assign leftOld   = prevActL && (prevAddrL == addrL);
  assign rightOld  = prevActR && (prevAddrR == addrR);

  always_comb begin
    if (ownerQ != OWN_NONE)       winner = ownerQ;
    else if (rightOld && !leftOld) winner = OWN_RIGHT;
    else                           winner = OWN_LEFT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerQ    <= OWN_NONE;
      prevActL  <= 1'b0;
      prevActR  <= 1'b0;
      prevAddrL <= '0;
      prevAddrR <= '0;
    end else begin
      ownerQ    <= (addrMatch && masterMode) ? winner : OWN_NONE;
      prevActL  <= !ceLN;
      prevActR  <= !ceRN;
      prevAddrL <= addrL;
      prevAddrR <= addrR;
    end
  end

  assign busyOutLN = !(rstN && masterMode && addrMatch && winner == OWN_RIGHT);
  assign busyOutRN = !(rstN && masterMode && addrMatch && winner == OWN_LEFT);

  assign effBusyLN = masterMode ? busyOutLN : busyInLN;
  assign effBusyRN = masterMode ? busyOutRN : busyInRN;

  always_comb begin
    strobeL.wrEn = rstN && !ceLN && !rdWrL && effBusyLN;
    strobeL.rdEn = rstN && !ceLN && rdWrL && !oeLN;
    strobeL.rdOk = effBusyLN;
    strobeR.wrEn = rstN && !ceRN && !rdWrR && effBusyRN;
    strobeR.rdEn = rstN && !ceRN && rdWrR && !oeRN;
    strobeR.rdOk = effBusyRN;
  end

  // R5
  no_dual_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyOutLN && !busyOutRN));
  // R5
  busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOutLN || !busyOutRN) |-> (!ceLN && !ceRN && addrL == addrR));
  // R12
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (busyOutLN && busyOutRN));
  // R7
  master_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !busyOutLN) |-> !strobeL.wrEn);
  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && addrMatch && $past(masterMode && addrMatch && !busyOutRN)) |-> !busyOutRN);
endmodule

// File: rtl/dpram_datapath.sv
module dpram_datapath
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobeL,
  input  portStrobe_t       strobeR,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wdataL,
  input  logic [DATA_W-1:0] wdataR,
  output logic [DATA_W-1:0] rdataL,
  output logic [DATA_W-1:0] rdataR,
  output logic              rdDriveL,
  output logic              rdDriveR,
  output logic              rdValidL,
  output logic              rdValidR
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // right first, then left: left data survives a same-address double write
  always_ff @(posedge clk) begin
    if (strobeR.wrEn) mem[addrR] <= wdataR;
    if (strobeL.wrEn) mem[addrL] <= wdataL;
  end

  portStrobe_t       stb  [2];
  logic [ADDR_W-1:0] addr [2];
  logic [DATA_W-1:0] rdQ  [2];
  logic              drvQ [2];
  logic              vldQ [2];

  assign stb[0]  = strobeL;
  assign stb[1]  = strobeR;
  assign addr[0] = addrL;
  assign addr[1] = addrR;

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdQ[p]  <= '0;
        drvQ[p] <= 1'b0;
        vldQ[p] <= 1'b0;
      end else begin
        drvQ[p] <= stb[p].rdEn;
        vldQ[p] <= stb[p].rdEn && stb[p].rdOk;
        if (stb[p].rdEn) rdQ[p] <= mem[addr[p]];
      end
    end
  end

  assign rdataL   = rdQ[0];
  assign rdataR   = rdQ[1];
  assign rdDriveL = drvQ[0];
  assign rdDriveR = drvQ[1];
  assign rdValidL = vldQ[0];
  assign rdValidR = vldQ[1];

  // R8
  valid_needs_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValidL |-> rdDriveL) and (rdValidR |-> rdDriveR));
  // R9
  left_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeL.wrEn |=> (mem[$past(addrL)] == $past(wdataL)));
  // R2
  right_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobeR.wrEn && !(strobeL.wrEn && addrL == addrR)) |=> (mem[$past(addrR)] == $past(wdataR)));
endmodule

// File: rtl/dpram_busy_gated.sv
module dpram_busy_gated
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              ceLN,
  input  logic              rdWrL,
  input  logic              oeLN,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] wdataL,
  input  logic              busyInLN,
  output logic [DATA_W-1:0] rdataL,
  output logic              rdDriveL,
  output logic              rdValidL,
  output logic              busyOutLN,
  input  logic              ceRN,
  input  logic              rdWrR,
  input  logic              oeRN,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wdataR,
  input  logic              busyInRN,
  output logic [DATA_W-1:0] rdataR,
  output logic              rdDriveR,
  output logic              rdValidR,
  output logic              busyOutRN
);
  portStrobe_t strobeL, strobeR;

  dpram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .ceLN(ceLN), .rdWrL(rdWrL), .oeLN(oeLN), .addrL(addrL), .busyInLN(busyInLN),
    .ceRN(ceRN), .rdWrR(rdWrR), .oeRN(oeRN), .addrR(addrR), .busyInRN(busyInRN),
    .busyOutLN(busyOutLN), .busyOutRN(busyOutRN),
    .strobeL(strobeL), .strobeR(strobeR)
  );

  dpram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobeL(strobeL), .strobeR(strobeR),
    .addrL(addrL), .addrR(addrR), .wdataL(wdataL), .wdataR(wdataR),
    .rdataL(rdataL), .rdataR(rdataR),
    .rdDriveL(rdDriveL), .rdDriveR(rdDriveR),
    .rdValidL(rdValidL), .rdValidR(rdValidR)
  );
endmodule

// File: tb/tb_dpram_busy_gated.sv
module tb_dpram_busy_gated;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b0;
  logic ceLN = 1, rdWrL = 1, oeLN = 1, busyInLN = 1;
  logic ceRN = 1, rdWrR = 1, oeRN = 1, busyInRN = 1;
  logic [10:0] addrL = 0, addrR = 0;
  logic [7:0]  wdataL = 0, wdataR = 0;
  logic [7:0]  rdataL, rdataR;
  logic rdDriveL, rdDriveR, rdValidL, rdValidR, busyOutLN, busyOutRN;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [16];
  logic [7:0] expDataL, expDataR;
  logic expDrvL, expDrvR, expVldL, expVldR;

  always #2.5 clk = ~clk;

  dpram_busy_gated dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ceLN = 1; ceRN = 1; rdWrL = 1; rdWrR = 1; oeLN = 1; oeRN = 1;
  endtask

  task automatic wrL(input logic [10:0] a, input logic [7:0] d);
    ceLN = 0; rdWrL = 0; addrL = a; wdataL = d;
  endtask

  task automatic rdL(input logic [10:0] a);
    ceLN = 0; rdWrL = 1; oeLN = 0; addrL = a;
  endtask

  // expected outcome of one slave-mode read
  function automatic logic expValid(input logic rd, input logic oe, input logic busyN);
    return rd && !oe && busyN;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 driveL", rdDriveL, 0); chk("R11 validR", rdValidR, 0);
    chk("R11 busyL", busyOutLN, 1); chk("R11 busyR", busyOutRN, 1);
    rstN = 1;
    tick();
    chk("R11 after reset drive", {rdDriveL, rdDriveR}, 0);

    // preload addresses 0..15 through left port, slave mode
    for (int i = 0; i < 16; i++) begin
      model[i] = 8'($urandom);
      wrL(11'(i), model[i]);
      tick();
    end
    idle();
    tick();

    // R3 basic read, and output enable high
    rdL(11'd3); tick();
    chk("R3 drive", rdDriveL, 1); chk("R3 data", rdataL, model[3]);
    chk("R8 valid when not busy", rdValidL, 1);
    ceLN = 0; rdWrL = 1; oeLN = 1; tick();
    chk("R3 oe high no drive", rdDriveL, 0);

    // R1 deselected write ignored
    idle(); ceLN = 1; rdWrL = 0; addrL = 11'd4; wdataL = ~model[4]; oeLN = 0; tick();
    chk("R1 no drive when deselected", rdDriveL, 0);
    rdL(11'd4); tick();
    chk("R1 word unchanged", rdataL, model[4]);

    // R4 slave inhibit blocks write
    idle(); busyInLN = 0; wrL(11'd5, ~model[5]); tick();
    busyInLN = 1; rdL(11'd5); tick();
    chk("R4 inhibited write dropped", rdataL, model[5]);
    // R12 busy outputs stay high in slave mode under match
    idle(); wrL(11'd6, 8'h11); ceRN = 0; rdWrR = 0; addrR = 11'd6; wdataR = 8'h22;
    #1;
    chk("R12 slave busyL", busyOutLN, 1); chk("R12 slave busyR", busyOutRN, 1);
    tick(); model[6] = 8'h11;                 // R9 left wins
    idle(); rdL(11'd6); tick();
    chk("R9 left data kept", rdataL, 8'h11);

    // R10 read on right during left write, same address
    idle(); wrL(11'd7, ~model[7]); ceRN = 0; rdWrR = 1; oeRN = 0; addrR = 11'd7; tick();
    chk("R10 old data", rdataR, model[7]);
    model[7] = ~model[7];
    idle(); tick();

    // random slave-mode traffic
    for (int n = 0; n < 600; n++) begin
      ceLN = 1'($urandom_range(0, 3) == 0); ceRN = 1'($urandom_range(0, 3) == 0);
      rdWrL = 1'($urandom); rdWrR = 1'($urandom);
      oeLN = 1'($urandom_range(0, 3) == 0); oeRN = 1'($urandom_range(0, 3) == 0);
      busyInLN = 1'($urandom_range(0, 3) != 0); busyInRN = 1'($urandom_range(0, 3) != 0);
      addrL = 11'($urandom_range(0, 15)); addrR = 11'($urandom_range(0, 15));
      wdataL = 8'($urandom); wdataR = 8'($urandom);
      expDrvL = !ceLN && rdWrL && !oeLN; expDrvR = !ceRN && rdWrR && !oeRN;
      expVldL = !ceLN && expValid(rdWrL, oeLN, busyInLN);
      expVldR = !ceRN && expValid(rdWrR, oeRN, busyInRN);
      expDataL = model[addrL[3:0]]; expDataR = model[addrR[3:0]];
      if (!ceRN && !rdWrR && busyInRN) model[addrR[3:0]] = wdataR;
      if (!ceLN && !rdWrL && busyInLN) model[addrL[3:0]] = wdataL;
      tick();
      chk("R3 rand driveL", rdDriveL, expDrvL); chk("R3 rand driveR", rdDriveR, expDrvR);
      chk("R8 rand validL", rdValidL, expVldL); chk("R8 rand validR", rdValidR, expVldR);
      if (expDrvL) chk("R2 rand dataL", rdataL, expDataL);
      if (expDrvR) chk("R2 rand dataR", rdataR, expDataR);
    end
    idle(); busyInLN = 1; busyInRN = 1; tick();

    // master mode: left first, right arrives later
    masterMode = 1;
    rdL(11'd9); tick();
    ceRN = 0; rdWrR = 0; addrR = 11'd9; wdataR = ~model[9]; busyInRN = 1; #1;
    chk("R6 earlier left wins busyR", busyOutRN, 0); chk("R5 left not busy", busyOutLN, 1);
    tick();
    chk("R6 grant held", busyOutRN, 0);
    rdWrR = 1; oeRN = 0; tick();
    chk("R8 busied read driven", rdDriveR, 1); chk("R8 busied read invalid", rdValidR, 0);
    idle(); tick();
    chk("R5 no match no busy", {busyOutLN, busyOutRN}, 2'b11);
    rdL(11'd9); tick();
    chk("R7 busied write dropped", rdataL, model[9]);

    // right first, left arrives later
    idle(); ceRN = 0; rdWrR = 1; oeRN = 1; addrR = 11'd10; tick();
    wrL(11'd10, ~model[10]); busyInLN = 1; #1;
    chk("R6 earlier right wins busyL", busyOutLN, 0);
    tick();
    idle(); rdL(11'd10); tick();
    chk("R7 left write dropped", rdataL, model[10]);

    // simultaneous arrival: left wins
    idle(); tick();
    wrL(11'd11, 8'h5a); ceRN = 0; rdWrR = 0; addrR = 11'd11; wdataR = 8'ha5; #1;
    chk("R6 tie busyR", busyOutRN, 0); chk("R6 tie busyL", busyOutLN, 1);
    tick();
    idle(); ceRN = 0; rdWrR = 1; oeRN = 0; addrR = 11'd11; tick();
    chk("R2 master winner stored", rdataR, 8'h5a);
    idle(); tick();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule